// File: doc/BRIEF.md
# Decaying Synaptic Conductance Register

This block keeps one synaptic conductance as an unsigned integer word. Each accepted input spike raises the word by that spike's weight. Between spikes the word shrinks geometrically toward zero. A decay step takes away the word shifted right by six bits, so the word is multiplied by 63/64. A free-running interval timer sets how often that step happens. Because the step interval is a count of clock cycles, the decay time constant grows linearly with the configured interval: tau ≈ −(interval+1) / (f_clk · ln(63/64)).

One instance serves one synapse type. Its output word drives a numeric-to-frequency converter further down the chain. The same block also works as a spike-frequency adaptation channel. To use it that way, tie the spike strobe to the neuron's own output spike and hold the weight at a small constant such as 1.

Top module: `syn_cond_trace`

## Requirements
- R1: A synchronous reset clears the conductance word and the interval counter to zero. The output reads 0 at the first sample after the reset edge.
- R2: A cycle with the spike strobe high and no decay step sets the word to its old value plus the 8-bit weight.
- R3: A decay step with no spike sets the word to v − floor(v/64).
- R4: The interval counter starts at 0 after reset and rises by one each cycle. When the count is greater than or equal to the interval input, a decay step occurs in that cycle and the counter returns to 0. With a steady interval N this gives one decay every N+1 cycles, and every cycle when N = 0.
- R5: When a spike and a decay step fall in the same cycle, the new word is v − floor(v/64) + weight. Both terms come from the value held before that edge.
- R6: The addition saturates at 65535 instead of wrapping.
- R7: Without a spike the word never increases. Once the word is below 64 it stays constant with no spike.
- R8: If the interval input drops below the running count, a decay step fires in the next cycle and the counter restarts from 0.
- R9: With the strobe low, the weight input has no effect on the word.
- R10: The output is registered. A change caused by the inputs at a clock edge appears on the output right after that edge and stays until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| spike_vld_i | input | 1 | One-cycle spike strobe |
| spike_wgt_i | input | 8 | Weight added on a spike |
| decay_ivl_i | input | 16 | Decay interval; one step every ivl+1 cycles |
| cond_o | output | 16 | Current conductance word |

## Verification
Every result of this block is due exactly one clock edge after its inputs are presented. This covers an add, a decay step, a combined update and a reset. The bench drives inputs on the falling edge. It advances its own arithmetic model of the value and the interval count at the next rising edge, then compares the output at the following falling edge. Because the bench tracks the decay timer itself, it knows at every cycle whether a step is due. This lets it confirm the N+1 spacing and the restart after the interval is lowered, judging only from when the value moves.

// File: rtl/syn_cond_pkg.sv
package syn_cond_pkg;
  localparam int unsigned DEF_COND_W  = 16;
  localparam int unsigned DEF_WGT_W   = 8;
  localparam int unsigned DEF_IVL_W   = 16;
  localparam int unsigned DEF_DECAY_SH = 6;

  // Kind of update applied at an edge, exported for the checker
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'b00,
    UPD_ADD   = 2'b01,
    UPD_DECAY = 2'b10,
    UPD_BOTH  = 2'b11
  } upd_kind_e;
endpackage

// File: rtl/decay_timer.sv
module decay_timer #(
  parameter int unsigned IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             tick_o,
  output logic [IVL_W-1:0] cnt_o
);
  logic [IVL_W-1:0] cnt_q;

  // >= rather than == so a lowered interval never strands the counter
  assign tick_o = (cnt_q >= ivl_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cond_update.sv
module cond_update #(
  parameter int unsigned COND_W   = 16,
  parameter int unsigned WGT_W    = 8,
  parameter int unsigned DECAY_SH = 6
) (
  input  logic [COND_W-1:0] cur_i,
  input  logic              add_en_i,
  input  logic [WGT_W-1:0]  wgt_i,
  input  logic              decay_en_i,
  output logic [COND_W-1:0] nxt_o,
  output syn_cond_pkg::upd_kind_e kind_o
);
  localparam int unsigned SUM_W = COND_W + 1;
  localparam logic [COND_W-1:0] MAXV = {COND_W{1'b1}};

  function automatic logic [COND_W-1:0] leak(input logic [COND_W-1:0] v);
    return v - (v >> DECAY_SH);
  endfunction

  function automatic logic [COND_W-1:0] sat_add(input logic [COND_W-1:0] v,
                                                input logic [WGT_W-1:0] w);
    logic [SUM_W-1:0] s;
    s = {1'b0, v} + SUM_W'(w);
    return s[COND_W] ? MAXV : s[COND_W-1:0];
  endfunction

  logic [COND_W-1:0] base;

  always_comb begin
    base   = decay_en_i ? leak(cur_i) : cur_i;
    nxt_o  = add_en_i ? sat_add(base, wgt_i) : base;
    kind_o = syn_cond_pkg::upd_kind_e'({decay_en_i, add_en_i});
  end
endmodule

// File: rtl/syn_cond_trace.sv
module syn_cond_trace
  import syn_cond_pkg::*;
#(
  parameter int unsigned COND_W   = DEF_COND_W,
  parameter int unsigned WGT_W    = DEF_WGT_W,
  parameter int unsigned IVL_W    = DEF_IVL_W,
  parameter int unsigned DECAY_SH = DEF_DECAY_SH
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              spike_vld_i,
  input  logic [WGT_W-1:0]  spike_wgt_i,
  input  logic [IVL_W-1:0]  decay_ivl_i,
  output logic [COND_W-1:0] cond_o
);
  logic              decay_tick;
  logic [IVL_W-1:0]  ivl_cnt;
  logic [COND_W-1:0] cond_q;
  logic [COND_W-1:0] cond_nxt;
  upd_kind_e         upd_kind;

  decay_timer #(.IVL_W(IVL_W)) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ivl_i  (decay_ivl_i),
    .tick_o (decay_tick),
    .cnt_o  (ivl_cnt)
  );

  cond_update #(.COND_W(COND_W), .WGT_W(WGT_W), .DECAY_SH(DECAY_SH)) u_upd (
    .cur_i      (cond_q),
    .add_en_i   (spike_vld_i),
    .wgt_i      (spike_wgt_i),
    .decay_en_i (decay_tick),
    .nxt_o      (cond_nxt),
    .kind_o     (upd_kind)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) cond_q <= '0;
    else       cond_q <= cond_nxt;
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/syn_cond_checker.sv
module syn_cond_checker
  import syn_cond_pkg::*;
#(
  parameter int unsigned COND_W = 16,
  parameter int unsigned WGT_W  = 8,
  parameter int unsigned IVL_W  = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              spike_vld_i,
  input logic [WGT_W-1:0]  spike_wgt_i,
  input logic [IVL_W-1:0]  decay_ivl_i,
  input logic [COND_W-1:0] cond_o,
  input logic              decay_tick,
  input logic [IVL_W-1:0]  ivl_cnt,
  input upd_kind_e         upd_kind
);
  localparam logic [COND_W:0] MAXV = {1'b0, {COND_W{1'b1}}};

  // R1: reset clears the word
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (cond_o == '0));

  // R4: counter restarts after a step and otherwise advances by one
  assert_tick_restart_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    decay_tick |=> (ivl_cnt == '0));
  assert_cnt_advance_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !decay_tick |=> (ivl_cnt == $past(ivl_cnt) + 1'b1));

  // R7: no spike never raises the word
  assert_no_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !spike_vld_i |=> (cond_o <= $past(cond_o)));

  // R9: idle cycle leaves the word unchanged
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_kind == UPD_HOLD) |=> $stable(cond_o));

  // R2: plain add below the ceiling
  assert_plain_add_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_kind == UPD_ADD && ({1'b0, cond_o} + (COND_W+1)'(spike_wgt_i)) <= MAXV)
    |=> (cond_o == $past(cond_o) + COND_W'($past(spike_wgt_i))));

  // R6: an add that would pass the ceiling lands on it
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (upd_kind == UPD_ADD && ({1'b0, cond_o} + (COND_W+1)'(spike_wgt_i)) > MAXV)
    |=> (cond_o == MAXV[COND_W-1:0]));
endmodule

bind syn_cond_trace syn_cond_checker #(
  .COND_W(COND_W), .WGT_W(WGT_W), .IVL_W(IVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .spike_vld_i (spike_vld_i),
  .spike_wgt_i (spike_wgt_i),
  .decay_ivl_i (decay_ivl_i),
  .cond_o      (cond_o),
  .decay_tick  (decay_tick),
  .ivl_cnt     (ivl_cnt),
  .upd_kind    (upd_kind)
);

// File: tb/tb_syn_cond_trace.sv
module tb_syn_cond_trace;
  logic        clk = 1'b0;
  logic        rst;
  logic        vld;
  logic [7:0]  wgt;
  logic [15:0] ivl;
  logic [15:0] cond;

  int n_run  = 0;
  int n_fail = 0;
  int m_val  = 0;   // bench model of the word
  int m_cnt  = 0;   // bench model of the interval count

  always #10 clk = ~clk;   // 50 MHz

  syn_cond_trace dut (
    .clk_i(clk), .rst_i(rst), .spike_vld_i(vld), .spike_wgt_i(wgt),
    .decay_ivl_i(ivl), .cond_o(cond)
  );

  // One cycle: inputs set now (falling edge), result checked at next falling edge (R10)
  task automatic step(input logic r, input logic v, input int w, input string tag);
    int e;
    bit dec;
    rst = r; vld = v; wgt = w[7:0];
    if (r) begin
      e = 0; m_cnt = 0;
    end else begin
      dec = (m_cnt >= int'(ivl));
      e = m_val;
      if (dec) e = e - e / 64;
      if (v) e = e + w;
      if (e > 65535) e = 65535;
      m_cnt = dec ? 0 : m_cnt + 1;
    end
    m_val = e;
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (int'(cond) != e) begin
      n_fail++;
      $display("FAIL %s: cond=%0d expected %0d", tag, cond, e);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, got 0 expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; vld = 1'b0; wgt = '0; ivl = 16'd1000;
    @(negedge clk);
    step(1, 0, 0, "R1 reset");
    step(1, 1, 200, "R1 reset holds with spike");

    // R2 / R9: weight sweep, idle cycles carry junk weights
    for (int w = 0; w < 256; w++) begin
      step(0, 1, w, "R2 add");
      step(0, 0, 255 - w, "R9 weight ignored");
    end

    // R6: drive to the ceiling and stay there
    for (int k = 0; k < 150; k++) step(0, 1, 255, "R6 saturate");

    // R3 / R7: decay every cycle until residual stalls below 64
    ivl = 16'd0;
    for (int k = 0; k < 600; k++) step(0, 0, 77, "R3 R7 decay to residual");
    if (m_val >= 64) begin
      n_fail++; n_run++;
      $display("FAIL R7: model residual=%0d expected <64", m_val);
    end

    // R4 / R5: several intervals, spikes landing on and off steps
    for (int n = 1; n <= 5; n++) begin
      ivl = 16'(n);
      step(1, 0, 0, "R1 restart");
      for (int k = 0; k < 40; k++) step(0, 1, 250, "R5 concurrent add and decay");
      for (int k = 0; k < 6 * (n + 1); k++) step(0, 0, 0, "R4 step spacing");
    end

    // R8: lower interval below running count
    ivl = 16'd50;
    step(1, 0, 0, "R1 restart");
    for (int k = 0; k < 20; k++) step(0, 1, 255, "R8 fill");
    for (int k = 0; k < 10; k++) step(0, 0, 0, "R8 pre");
    ivl = 16'd5;
    for (int k = 0; k < 30; k++) step(0, 0, 0, "R8 lowered interval");

    // R1: reset mid-run
    ivl = 16'd3;
    for (int k = 0; k < 10; k++) step(0, 1, 99, "R5 mixed");
    step(1, 1, 99, "R1 mid-run reset");
    for (int k = 0; k < 12; k++) step(0, 1, 1, "R4 adaptation weight after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule